// File: doc/BRIEF.md
# Power-Management Command Port with SMI Gating

This block sits on a simple byte-wide register bus. A host writes command bytes to a command register. Two reserved codes only turn a system-wide ACPI-mode flag on or off. Every other code asks for a System Management Interrupt (SMI), and the request goes out only when a gate bit in a small bank of configuration bytes allows it. The SMI output is a level. It stays high until the host pulses an acknowledge input.

The block also holds a free scratch status byte. It exposes the ACPI-mode flag as bit 0 of a read-only power-management control register, and it provides a combinational read path for every register. A parameter states whether SMM support exists. When it does not, the gate byte comes out of reset with its gate bit already set, which marks SMM as initialised. As a result, any non-reserved command raises SMI from reset onward.

Top module: `pmcmd_port`

## Requirements
- R1: After reset, acpiMode and smiReq are 0, and the command, status and PM control registers read 0. The configuration bytes at 0x58, 0x59 and 0x5A read 0. Byte 0x5B reads 0x00 when SMM_SUPPORT is 1 and 0x02 when it is 0.
- R2: A bus write of 0xF1 to the command register (address 0x00) sets acpiMode on the following clock edge and raises no SMI.
- R3: A bus write of 0xF0 to the command register clears acpiMode on the following clock edge and raises no SMI.
- R4: A bus write of any code other than 0xF0 or 0xF1 to the command register, while bit 1 of configuration byte 0x5B is 1, drives smiReq to 1 on the following edge and leaves acpiMode unchanged.
- R5: A bus write of any code other than 0xF0 or 0xF1 while bit 1 of byte 0x5B is 0 leaves smiReq at 0.
- R6: smiReq stays at 1 until a cycle in which smiAck is 1, and it is 0 after that edge. A qualifying command in the same cycle as smiAck, or while smiReq is already 1, leaves it at 1.
- R7: The command register (address 0x00) reads back the last byte written to it, including the reserved codes.
- R8: The status byte (address 0x01) is read/write scratch, and writing it changes neither acpiMode nor smiReq.
- R9: The PM control register (address 0x04) reads {7'b0, acpiMode}. Writes to it are ignored.
- R10: Configuration bytes 0x58 to 0x5B are read/write. Reads of unmapped addresses return 0, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address for read and write |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| smiAck | input | 1 | Host acknowledge; clears smiReq |
| smiReq | output | 1 | SMI request level |
| acpiMode | output | 1 | ACPI mode (SCI enable) flag |

## Verification
The assertions assume three things about the inputs. Commands arrive only through busWrEn writes to the command address. The bus presents at most one write per cycle. smiAck is a pulse that the host gives only to retire a request. The stimulus keeps to these rules: every write is a one-cycle strobe with the address held for that cycle, and acknowledges are single-cycle pulses driven away from the clock edge. The 256-code sweep clears any pending request before each code, so each result depends on that code alone.

// File: rtl/pmcmd_pkg.sv
package pmcmd_pkg;
  // Strobes from decode control to the register datapath
  typedef struct packed {
    logic cmdWr;
    logic statWr;
    logic acpiSet;
    logic acpiClr;
    logic smiRaise;
    logic smiDrop;
  } pmStrobes_t;
endpackage

// File: rtl/pmcmd_ctrl.sv
module pmcmd_ctrl
  import pmcmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CMD_ADDR  = 'h00,
  parameter int STAT_ADDR = 'h01,
  parameter int CFG_BASE  = 'h58,
  parameter int CFG_COUNT = 4,
  parameter int ACPI_ON   = 'hF1,
  parameter int ACPI_OFF  = 'hF0
) (
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 gateOpen,
  input  logic                 smiAck,
  output pmStrobes_t           strb,
  output logic [CFG_COUNT-1:0] cfgWrSel
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [DATA_W-1:0] ON_C   = DATA_W'(ACPI_ON);
  localparam logic [DATA_W-1:0] OFF_C  = DATA_W'(ACPI_OFF);

  logic cmdHit;
  logic isOn;
  logic isOff;
  logic reservedCode;

  assign cmdHit       = busWrEn && (busAddr == CMD_A);
  assign isOn         = (busWrData == ON_C);
  assign isOff        = (busWrData == OFF_C);
  assign reservedCode = isOn || isOff;

  always_comb begin
    strb          = '0;
    strb.cmdWr    = cmdHit;
    strb.statWr   = busWrEn && (busAddr == STAT_A);
    strb.acpiSet  = cmdHit && isOn;
    strb.acpiClr  = cmdHit && isOff;
    // reserved codes never reach the SMI path
    strb.smiRaise = cmdHit && !reservedCode && gateOpen;
    strb.smiDrop  = smiAck;
  end

  for (genvar i = 0; i < CFG_COUNT; i++) begin : g_cfgSel
    assign cfgWrSel[i] = busWrEn && (busAddr == ADDR_W'(CFG_BASE + i));
  end
endmodule

// File: rtl/pmcmd_dp.sv
module pmcmd_dp
  import pmcmd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CMD_ADDR    = 'h00,
  parameter int STAT_ADDR   = 'h01,
  parameter int PM1_ADDR    = 'h04,
  parameter int CFG_BASE    = 'h58,
  parameter int CFG_COUNT   = 4,
  parameter int GATE_IDX    = 3,
  parameter int GATE_BIT    = 1,
  parameter bit SMM_SUPPORT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  pmStrobes_t           strb,
  input  logic [CFG_COUNT-1:0] cfgWrSel,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 gateOpen,
  output logic                 acpiMode,
  output logic                 smiReq
);
  localparam logic [DATA_W-1:0] SMM_DONE = DATA_W'(1) << GATE_BIT;

  function automatic logic [DATA_W-1:0] cfgResetVal(input int idx);
    if (idx == GATE_IDX && !SMM_SUPPORT) return SMM_DONE;
    return '0;
  endfunction

  logic [DATA_W-1:0]                 cmdReg;
  logic [DATA_W-1:0]                 statReg;
  logic [CFG_COUNT-1:0][DATA_W-1:0] cfgBank;
  logic                              acpiReg;
  logic                              smiReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      statReg <= '0;
      acpiReg <= 1'b0;
      smiReg  <= 1'b0;
    end else begin
      if (strb.cmdWr)   cmdReg  <= busWrData;
      if (strb.statWr)  statReg <= busWrData;
      if (strb.acpiSet) acpiReg <= 1'b1;
      else if (strb.acpiClr) acpiReg <= 1'b0;
      // a new request outranks an acknowledge in the same cycle
      if (strb.smiRaise)     smiReg <= 1'b1;
      else if (strb.smiDrop) smiReg <= 1'b0;
    end
  end

  for (genvar i = 0; i < CFG_COUNT; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)            cfgBank[i] <= cfgResetVal(i);
      else if (cfgWrSel[i]) cfgBank[i] <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(CMD_ADDR))  busRdData = cmdReg;
    if (busAddr == ADDR_W'(STAT_ADDR)) busRdData = statReg;
    if (busAddr == ADDR_W'(PM1_ADDR))  busRdData = {{(DATA_W-1){1'b0}}, acpiReg};
    for (int i = 0; i < CFG_COUNT; i++) begin
      if (busAddr == ADDR_W'(CFG_BASE + i)) busRdData = cfgBank[i];
    end
  end

  assign gateOpen = cfgBank[GATE_IDX][GATE_BIT];
  assign acpiMode = acpiReg;
  assign smiReq   = smiReg;
endmodule

// File: rtl/pmcmd_port.sv
module pmcmd_port
  import pmcmd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CMD_ADDR    = 'h00,
  parameter int STAT_ADDR   = 'h01,
  parameter int PM1_ADDR    = 'h04,
  parameter int CFG_BASE    = 'h58,
  parameter int CFG_COUNT   = 4,
  parameter int GATE_IDX    = 3,
  parameter int GATE_BIT    = 1,
  parameter int ACPI_ON     = 'hF1,
  parameter int ACPI_OFF    = 'hF0,
  parameter bit SMM_SUPPORT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              smiAck,
  output logic              smiReq,
  output logic              acpiMode
);
  pmStrobes_t           strb;
  logic [CFG_COUNT-1:0] cfgWrSel;
  logic                 gateOpen;

  pmcmd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR),
    .CFG_BASE(CFG_BASE), .CFG_COUNT(CFG_COUNT), .ACPI_ON(ACPI_ON), .ACPI_OFF(ACPI_OFF)
  ) uCtrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .gateOpen(gateOpen), .smiAck(smiAck), .strb(strb), .cfgWrSel(cfgWrSel)
  );

  pmcmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR),
    .PM1_ADDR(PM1_ADDR), .CFG_BASE(CFG_BASE), .CFG_COUNT(CFG_COUNT),
    .GATE_IDX(GATE_IDX), .GATE_BIT(GATE_BIT), .SMM_SUPPORT(SMM_SUPPORT)
  ) uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .strb(strb), .cfgWrSel(cfgWrSel), .busRdData(busRdData),
    .gateOpen(gateOpen), .acpiMode(acpiMode), .smiReq(smiReq)
  );
endmodule

// File: rtl/pmcmd_port_chk.sv
module pmcmd_port_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CMD_ADDR = 'h00,
  parameter int PM1_ADDR = 'h04,
  parameter int ACPI_ON  = 'hF1,
  parameter int ACPI_OFF = 'hF0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              smiAck,
  input logic              smiReq,
  input logic              acpiMode
);
  logic cmdWr;
  logic onWr;
  logic offWr;
  assign cmdWr = busWrEn && (busAddr == ADDR_W'(CMD_ADDR));
  assign onWr  = cmdWr && (busWrData == DATA_W'(ACPI_ON));
  assign offWr = cmdWr && (busWrData == DATA_W'(ACPI_OFF));

  AST_ACPI_SET: assert property (@(posedge clk) disable iff (!rstN) onWr |=> acpiMode) else $error("AST_ACPI_SET"); // R2
  AST_ACPI_CLR: assert property (@(posedge clk) disable iff (!rstN) offWr |=> !acpiMode) else $error("AST_ACPI_CLR"); // R3
  AST_RESERVED_NO_SMI: assert property (@(posedge clk) disable iff (!rstN) (onWr || offWr) && !smiReq |=> !smiReq) else $error("AST_RESERVED_NO_SMI"); // R3
  AST_ACPI_HOLD: assert property (@(posedge clk) disable iff (!rstN) !cmdWr |=> $stable(acpiMode)) else $error("AST_ACPI_HOLD"); // R4
  AST_SMI_HOLD: assert property (@(posedge clk) disable iff (!rstN) smiReq && !smiAck |=> smiReq) else $error("AST_SMI_HOLD"); // R6
  AST_SMI_RETIRE: assert property (@(posedge clk) disable iff (!rstN) smiReq && smiAck && !cmdWr |=> !smiReq) else $error("AST_SMI_RETIRE"); // R6
  AST_PM1_VIEW: assert property (@(posedge clk) disable iff (!rstN) busAddr == ADDR_W'(PM1_ADDR) |-> busRdData == DATA_W'(acpiMode)) else $error("AST_PM1_VIEW"); // R9
endmodule

bind pmcmd_port pmcmd_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .PM1_ADDR(PM1_ADDR),
  .ACPI_ON(ACPI_ON), .ACPI_OFF(ACPI_OFF)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .busRdData(busRdData), .smiAck(smiAck), .smiReq(smiReq), .acpiMode(acpiMode)
);

// File: tb/sim_pmcmd_port.sv
module sim_pmcmd_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       smiAck = 1'b0;
  logic [7:0] rd0, rd1;
  logic       smi0, smi1, acpi0, acpi1;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pmcmd_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd0), .smiAck(smiAck), .smiReq(smi0), .acpiMode(acpi0)
  );

  pmcmd_port #(.SMM_SUPPORT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd1), .smiAck(smiAck), .smiReq(smi1), .acpiMode(acpi1)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] a;
    logic [7:0] d;
    logic       ack;
    logic       eAcpi;
    logic       eSmi;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h00, 8'hF1, 1'b0, 1'b1, 1'b0},  // R2
    '{1'b1, 8'h00, 8'h10, 1'b0, 1'b1, 1'b1},  // R4 gate set from reset
    '{1'b1, 8'h00, 8'h22, 1'b0, 1'b1, 1'b1},  // R6 new command while pending
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0},  // R6 acknowledge
    '{1'b1, 8'h00, 8'hF0, 1'b0, 1'b0, 1'b0},  // R3
    '{1'b1, 8'h01, 8'h5A, 1'b0, 1'b0, 1'b0},  // R8
    '{1'b1, 8'h5B, 8'h00, 1'b0, 1'b0, 1'b0},  // R10 gate off
    '{1'b1, 8'h00, 8'h33, 1'b0, 1'b0, 1'b0},  // R5
    '{1'b1, 8'h5B, 8'h02, 1'b0, 1'b0, 1'b0},  // R10 gate on
    '{1'b1, 8'h00, 8'h44, 1'b1, 1'b0, 1'b1},  // R6 raise beats ack
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 0}      // R6
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one bus cycle: inputs set after a falling edge, results sampled at the next
  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d, input logic ack);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; smiAck = ack;
    @(negedge clk);
    busWrEn = 1'b0; smiAck = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    busAddr = a;
    #1;
    chk(req, rd0, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic expAcpi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, both SMM variants
    chk("R1 acpi", {7'b0, acpi0}, 8'h00);
    chk("R1 smi", {7'b0, smi0}, 8'h00);
    rdChk("R1 cmd", 8'h00, 8'h00);
    rdChk("R1 stat", 8'h01, 8'h00);
    rdChk("R1 pm1", 8'h04, 8'h00);
    for (int i = 0; i < 3; i++) rdChk("R1 cfg", 8'h58 + 8'(i), 8'h00);
    rdChk("R1 gate nosmm", 8'h5B, 8'h02);
    busAddr = 8'h5B; #1;
    chk("R1 gate smm", rd1, 8'h00);
    chk("R1 smi u1", {7'b0, smi1}, 8'h00);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      cyc(VECS[k].we, VECS[k].a, VECS[k].d, VECS[k].ack);
      chk($sformatf("R2-R6 vec%0d acpi", k), {7'b0, acpi0}, {7'b0, VECS[k].eAcpi});
      chk($sformatf("R2-R6 vec%0d smi", k), {7'b0, smi0}, {7'b0, VECS[k].eSmi});
    end
    rdChk("R7 last cmd", 8'h00, 8'h44);
    rdChk("R8 scratch", 8'h01, 8'h5A);
    rdChk("R10 cfg readback", 8'h5B, 8'h02);
    rdChk("R9 pm1 off", 8'h04, 8'h00);

    // R9 writes to PM control ignored
    cyc(1'b1, 8'h04, 8'hFF, 1'b0);
    chk("R9 acpi after pm1 write", {7'b0, acpi0}, 8'h00);
    rdChk("R9 pm1 after write", 8'h04, 8'h00);
    // R10 unmapped write/read
    cyc(1'b1, 8'h30, 8'hAA, 1'b0);
    rdChk("R10 unmapped", 8'h30, 8'h00);
    rdChk("R10 cmd untouched", 8'h00, 8'h44);
    rdChk("R10 stat untouched", 8'h01, 8'h5A);
    for (int i = 0; i < 4; i++) rdChk("R10 cfg untouched", 8'h58 + 8'(i), (i == 3) ? 8'h02 : 8'h00);
    cyc(1'b1, 8'h59, 8'hC3, 1'b0);
    rdChk("R10 cfg rw", 8'h59, 8'hC3);
    // R7 reserved code is recorded, R9 reflects flag
    cyc(1'b1, 8'h00, 8'hF1, 1'b0);
    rdChk("R7 reserved kept", 8'h00, 8'hF1);
    rdChk("R9 pm1 on", 8'h04, 8'h01);
    // R8 status write leaves flags alone
    cyc(1'b1, 8'h01, 8'h00, 1'b0);
    chk("R8 acpi kept", {7'b0, acpi0}, 8'h01);
    chk("R8 smi kept", {7'b0, smi0}, 8'h00);

    // sweep of all codes with gate clear then set
    expAcpi = acpi0;
    for (int g = 0; g < 2; g++) begin
      cyc(1'b1, 8'h5B, (g == 1) ? 8'h02 : 8'h00, 1'b0);
      for (int c = 0; c < 256; c++) begin
        logic eSmi;
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        cyc(1'b1, 8'h00, 8'(c), 1'b0);
        if (c == 'hF1) expAcpi = 1'b1;
        else if (c == 'hF0) expAcpi = 1'b0;
        eSmi = (g == 1) && (c != 'hF0) && (c != 'hF1);
        chk($sformatf("R4/R5 code %02h gate %0d smi", c, g), {7'b0, smi0}, {7'b0, eSmi});
        chk($sformatf("R2/R3 code %02h gate %0d acpi", c, g), {7'b0, acpi0}, {7'b0, expAcpi});
      end
    end
    summary();
  end
endmodule